// File: doc/BRIEF.md
# Scan-Based Logic Self-Test Sequencer

This block runs a built-in self-test over a group of parallel scan chains. A 16-bit pseudo-random generator supplies the stimulus. An XOR spreading network turns the generator state into one serial bit per chain, so that neighbouring chains do not receive shifted copies of the same stream. While each new pattern is shifted in, the response to the previous pattern leaves the chains. A multi-input signature register folds that response into a 16-bit signature.

A sequencer alternates shift phases with single capture cycles and counts both bits and patterns. A run of `NUM_PATTERNS` patterns on chains of `CHAIN_LEN` cells takes `NUM_PATTERNS*(CHAIN_LEN+1)+CHAIN_LEN` cycles of shifting and capturing. The last `CHAIN_LEN` of those cycles unload the final response. One compare cycle then checks the signature against `expected_sig` and reports pass or fail. The verdict and the done flag hold until the next accepted start. The surrounding logic supplies the circuit under test, the scan cells themselves and the expected signature.

Top module: `lbist_ctrl`

## Requirements
- R1: While reset is active and after reset releases, scan_en, done, pass and fail are all low.
- R2: A start pulse is taken only when the sequencer is idle or done; a start pulse during a run leaves the timing and the verdict of that run unchanged.
- R3: Each pattern is applied as CHAIN_LEN consecutive cycles with scan_en high followed by exactly one capture cycle with scan_en low. After NUM_PATTERNS such groups there are CHAIN_LEN more cycles with scan_en high (final unload), then one cycle with scan_en low (compare).
- R4: done rises exactly NUM_PATTERNS*(CHAIN_LEN+1)+CHAIN_LEN+1 clock edges after the edge that accepts start.
- R5: The generator is a 16-bit left-shifting Galois register with feedback mask 0x100B: next = (g<<1) ^ (g[15] ? 0x100B : 0). It is loaded with SEED when start is accepted and advances once per pattern-shift cycle. It holds during capture, final unload and compare.
- R6: Chain input i is g[(3i) mod 16] ^ g[(3i+7) mod 16] ^ g[(3i+12) mod 16], taken from the current generator state g. The first pattern-shift cycle of a run therefore presents the spread value of SEED.
- R7: The signature register is cleared to 0 when start is accepted. It updates as s = (s<<1) ^ (s[15] ? 0x1021 : 0) ^ chain_so, with chain_so on the low bits. It updates on every pattern-shift cycle except those of the first pattern, and on every final-unload cycle. At all other times it holds.
- R8: In the compare cycle, pass is set when the signature equals expected_sig and fail is set otherwise. Exactly one of them is high whenever done is high, and neither is high while done is low.
- R9: done, pass and fail hold their values until the next accepted start, and drop on the edge that accepts it.
- R10: The contents of the chains before the first pattern has been loaded have no influence on the final signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run |
| expected_sig | input | 16 | Golden signature, sampled in the compare cycle |
| chain_so | input | NUM_CHAINS | Serial outputs of the scan chains |
| scan_en | output | 1 | High: chains shift; low: chains capture |
| chain_si | output | NUM_CHAINS | Serial inputs to the scan chains |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Signature matched, held with done |
| fail | output | 1 | Signature mismatched, held with done |

## Verification
Loading pattern k+1 and compacting response k happen in the same cycle. In every shift cycle after the first pattern, the generator advances while the signature register absorbs the bits leaving the chains. The bench provokes this by modelling the chains and a nonlinear response function, then checking the spread stream cycle by cycle against a scoreboard queue. It also computes its own signature from the observed serial outputs, using only cycles it counts as carrying response data. A second run preloads the chains with different stale contents, so it passes only if the overlap is aligned and the first load is kept out of the signature. A start pulse injected mid-run must leave the cycle count and the verdict untouched.

// File: rtl/lbist_pkg.sv
`timescale 1ns/1ps
package lbist_pkg;

    localparam int unsigned SIG_W = 16;
    localparam logic [SIG_W-1:0] GEN_MASK = 16'h100B;
    localparam logic [SIG_W-1:0] CMP_MASK = 16'h1021;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAPTURE,
        ST_UNLOAD,
        ST_COMPARE,
        ST_DONE
    } lbist_state_e;

endpackage

// File: rtl/lbist_prpg.sv
`timescale 1ns/1ps
module lbist_prpg #(
    parameter int unsigned    W    = 16,
    parameter logic [W-1:0]   MASK = 16'h100B,
    parameter logic [W-1:0]   SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    output logic [W-1:0] state
);

    logic [W-1:0] gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (load) begin
            gen_d = SEED;
        end else if (adv) begin
            gen_d = {gen_q[W-2:0], 1'b0} ^ (gen_q[W-1] ? MASK : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= SEED;
        else        gen_q <= gen_d;
    end

    assign state = gen_q;

endmodule

// File: rtl/lbist_phase_shift.sv
`timescale 1ns/1ps
module lbist_phase_shift #(
    parameter int unsigned W = 16,
    parameter int unsigned N = 4
) (
    input  logic [W-1:0] gen,
    output logic [N-1:0] si
);

    for (genvar i = 0; i < N; i++) begin : g_tap
        localparam int unsigned TA = (3 * i) % W;
        localparam int unsigned TB = (3 * i + 7) % W;
        localparam int unsigned TC = (3 * i + 12) % W;
        assign si[i] = gen[TA] ^ gen[TB] ^ gen[TC];
    end

endmodule

// File: rtl/lbist_misr.sv
`timescale 1ns/1ps
module lbist_misr #(
    parameter int unsigned  W    = 16,
    parameter int unsigned  N    = 4,
    parameter logic [W-1:0] MASK = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [N-1:0] din,
    output logic [W-1:0] sig
);

    logic [W-1:0] sig_d, sig_q;

    always_comb begin
        sig_d = sig_q;
        if (clr) begin
            sig_d = '0;
        end else if (en) begin
            sig_d = {sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? MASK : '0)
                  ^ {{(W-N){1'b0}}, din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    assign sig = sig_q;

endmodule

// File: rtl/lbist_ctrl.sv
`timescale 1ns/1ps
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int unsigned        CHAIN_LEN    = 32,
    parameter int unsigned        NUM_PATTERNS = 64,
    parameter int unsigned        NUM_CHAINS   = 4,
    parameter logic [SIG_W-1:0]   SEED         = 16'hACE1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [SIG_W-1:0]      expected_sig,
    input  logic [NUM_CHAINS-1:0] chain_so,
    output logic                  scan_en,
    output logic [NUM_CHAINS-1:0] chain_si,
    output logic                  done,
    output logic                  pass,
    output logic                  fail
);

    localparam int unsigned SH_W  = (CHAIN_LEN > 1)    ? $clog2(CHAIN_LEN)    : 1;
    localparam int unsigned PAT_W = (NUM_PATTERNS > 1) ? $clog2(NUM_PATTERNS) : 1;
    localparam logic [SH_W-1:0]  SH_LAST  = SH_W'(CHAIN_LEN - 1);
    localparam logic [PAT_W-1:0] PAT_LAST = PAT_W'(NUM_PATTERNS - 1);

    typedef struct packed {
        lbist_state_e     state;
        logic [SH_W-1:0]  sh_cnt;
        logic [PAT_W-1:0] pat_cnt;
        logic             pass;
        logic             fail;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic             start_go;
    logic             gen_adv;
    logic             cmp_en;
    logic [SIG_W-1:0] gen_state;
    logic [SIG_W-1:0] sig_state;

    always_comb begin
        start_go = start && (ctl_q.state == ST_IDLE || ctl_q.state == ST_DONE);
        gen_adv  = (ctl_q.state == ST_SHIFT);
        cmp_en   = (ctl_q.state == ST_SHIFT && ctl_q.pat_cnt != '0)
                || (ctl_q.state == ST_UNLOAD);

        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    ctl_d.state   = ST_SHIFT;
                    ctl_d.sh_cnt  = '0;
                    ctl_d.pat_cnt = '0;
                    ctl_d.pass    = 1'b0;
                    ctl_d.fail    = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (ctl_q.sh_cnt == SH_LAST) begin
                    ctl_d.state  = ST_CAPTURE;
                    ctl_d.sh_cnt = '0;
                end else begin
                    ctl_d.sh_cnt = ctl_q.sh_cnt + 1'b1;
                end
            end
            ST_CAPTURE: begin
                if (ctl_q.pat_cnt == PAT_LAST) begin
                    ctl_d.state = ST_UNLOAD;
                end else begin
                    ctl_d.state   = ST_SHIFT;
                    ctl_d.pat_cnt = ctl_q.pat_cnt + 1'b1;
                end
            end
            ST_UNLOAD: begin
                if (ctl_q.sh_cnt == SH_LAST) begin
                    ctl_d.state  = ST_COMPARE;
                    ctl_d.sh_cnt = '0;
                end else begin
                    ctl_d.sh_cnt = ctl_q.sh_cnt + 1'b1;
                end
            end
            ST_COMPARE: begin
                ctl_d.state = ST_DONE;
                ctl_d.pass  = (sig_state == expected_sig);
                ctl_d.fail  = (sig_state != expected_sig);
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, sh_cnt: '0, pat_cnt: '0, pass: 1'b0, fail: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lbist_prpg #(
        .W    (SIG_W),
        .MASK (GEN_MASK),
        .SEED (SEED)
    ) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_go),
        .adv   (gen_adv),
        .state (gen_state)
    );

    lbist_phase_shift #(
        .W (SIG_W),
        .N (NUM_CHAINS)
    ) u_spread (
        .gen (gen_state),
        .si  (chain_si)
    );

    lbist_misr #(
        .W    (SIG_W),
        .N    (NUM_CHAINS),
        .MASK (CMP_MASK)
    ) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_go),
        .en    (cmp_en),
        .din   (chain_so),
        .sig   (sig_state)
    );

    assign scan_en = (ctl_q.state == ST_SHIFT) || (ctl_q.state == ST_UNLOAD);
    assign done    = (ctl_q.state == ST_DONE);
    assign pass    = ctl_q.pass;
    assign fail    = ctl_q.fail;

endmodule

// File: rtl/lbist_ctrl_chk.sv
`timescale 1ns/1ps
module lbist_ctrl_chk
    import lbist_pkg::*;
#(
    parameter logic [SIG_W-1:0] SEED = 16'hACE1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             scan_en,
    input logic             done,
    input logic             pass,
    input logic             fail,
    input lbist_state_e     state,
    input logic [SIG_W-1:0] gen_state,
    input logic [SIG_W-1:0] sig_state
);

    // R2: a start pulse during capture does not divert the run
    a_r2_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE && start) |=> (state == ST_SHIFT || state == ST_UNLOAD));

    // R3: capture lasts a single cycle and is followed by shifting
    a_r3_capture_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE) |=> scan_en);

    // R5: generator reloads to the seed on an accepted start
    a_r5_gen_seeded: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (state == ST_IDLE || state == ST_DONE)) |=> (gen_state == SEED));

    // R5: generator holds outside pattern shifting
    a_r5_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE || state == ST_UNLOAD || state == ST_COMPARE)
        |=> $stable(gen_state));

    // R7: signature cleared on accepted start
    a_r7_sig_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (state == ST_IDLE || state == ST_DONE)) |=> (sig_state == '0));

    // R7: signature holds across capture and compare
    a_r7_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE || state == ST_COMPARE) |=> $stable(sig_state));

    // R8: verdict is exclusive and only present with done
    a_r8_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass ^ fail));
    a_r8_no_verdict_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!pass && !fail));

    // R9: done and verdict held while no start arrives
    a_r9_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fail)));

endmodule

bind lbist_ctrl lbist_ctrl_chk #(
    .SEED (SEED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .scan_en   (scan_en),
    .done      (done),
    .pass      (pass),
    .fail      (fail),
    .state     (ctl_q.state),
    .gen_state (gen_state),
    .sig_state (sig_state)
);

// File: tb/lbist_ctrl_tb.sv
`timescale 1ns/1ps
module lbist_ctrl_tb;

    localparam int          LEN  = 8;
    localparam int          NP   = 5;
    localparam int          NC   = 4;
    localparam logic [15:0] SEED = 16'hACE1;
    localparam int          RUN_CYC = NP * (LEN + 1) + LEN + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          arm = 1'b0;
    logic [15:0]   expected_sig = '0;
    logic [NC-1:0] chain_so;
    logic          scan_en;
    logic [NC-1:0] chain_si;
    logic          done, pass, fail;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    lbist_ctrl #(
        .CHAIN_LEN    (LEN),
        .NUM_PATTERNS (NP),
        .NUM_CHAINS   (NC),
        .SEED         (SEED)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .expected_sig (expected_sig),
        .chain_so     (chain_so),
        .scan_en      (scan_en),
        .chain_si     (chain_si),
        .done         (done),
        .pass         (pass),
        .fail         (fail)
    );

    // ---------------- circuit under test and scan chains ----------------
    logic [LEN-1:0] ch [NC];
    logic           preload = 1'b0;
    logic [LEN-1:0] preload_val = '0;

    for (genvar c = 0; c < NC; c++) begin : g_so
        assign chain_so[c] = ch[c][LEN-1];
    end

    always @(posedge clk) begin
        logic [LEN-1:0] nx [NC];
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < LEN; k++) begin
                nx[c][k] = ch[c][k] ^ ch[(c+1)%NC][(k+3)%LEN]
                         ^ (ch[c][(k+1)%LEN] & ch[(c+3)%NC][k]);
            end
        end
        for (int c = 0; c < NC; c++) begin
            if (preload)      ch[c] <= preload_val ^ LEN'(c * 37);
            else if (scan_en) ch[c] <= {ch[c][LEN-2:0], chain_si[c]};
            else              ch[c] <= nx[c];
        end
    end

    // ---------------- reference signature (R7, R10) ----------------
    function automatic logic [15:0] sig_step(input logic [15:0] s, input logic [NC-1:0] d);
        return {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0000) ^ {{(16-NC){1'b0}}, d};
    endfunction

    function automatic logic [15:0] gen_step(input logic [15:0] g);
        return {g[14:0], 1'b0} ^ (g[15] ? 16'h100B : 16'h0000);
    endfunction

    function automatic logic [NC-1:0] spread(input logic [15:0] g);
        logic [NC-1:0] r;
        for (int i = 0; i < NC; i++) r[i] = g[(3*i)%16] ^ g[(3*i+7)%16] ^ g[(3*i+12)%16];
        return r;
    endfunction

    logic [15:0] ref_sig = '0;
    int          hi_seen = 0;

    always @(posedge clk) begin
        if (arm) begin
            ref_sig <= '0;
            hi_seen <= 0;
        end else if (scan_en) begin
            if (hi_seen >= LEN) ref_sig <= sig_step(ref_sig, chain_so);
            hi_seen <= hi_seen + 1;
        end
    end

    // ---------------- scoreboard for the chain input stream ----------------
    logic [NC-1:0] exp_q [$];
    int            mon_cnt = 0;
    int            stream_err = 0;
    logic [NC-1:0] bad_act = '0, bad_exp = '0;

    task automatic push_stream();
        logic [15:0] g = SEED;
        exp_q.delete();
        for (int i = 0; i < NP * LEN; i++) begin
            exp_q.push_back(spread(g));
            g = gen_step(g);
        end
    endtask

    always @(negedge clk) begin
        if (arm) begin
            mon_cnt = 0;
        end else if (scan_en && mon_cnt < NP * LEN) begin
            logic [NC-1:0] e;
            mon_cnt++;
            if (exp_q.size() == 0) begin
                stream_err++;
            end else begin
                e = exp_q.pop_front();
                if (e !== chain_si) begin
                    if (stream_err == 0) begin
                        bad_act = chain_si;
                        bad_exp = e;
                    end
                    stream_err++;
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int cyc, hi, lo, badrun;

    task automatic run(input logic [15:0] exp_sig, input bit poke);
        int run_len;
        @(posedge clk); #1;
        start = 1'b1; arm = 1'b1; expected_sig = exp_sig;
        @(posedge clk); #1;
        start = 1'b0; arm = 1'b0;
        cyc = 0; hi = 0; lo = 0; badrun = 0; run_len = 0;
        forever begin
            @(negedge clk);
            if (cyc == 0) check("R9 done drops on accepted start", 32'(done), 32'd0);
            if (done) break;
            if (scan_en) begin
                hi++; run_len++;
            end else begin
                lo++;
                if (run_len != LEN) badrun++;
                run_len = 0;
            end
            if (poke && cyc == 20) start = 1'b1;
            if (poke && cyc == 21) start = 1'b0;
            if (poke && cyc == NP * (LEN + 1) - 1) start = 1'b1;
            if (poke && cyc == NP * (LEN + 1))     start = 1'b0;
            cyc++;
            if (cyc > 5000) begin
                check("R4 run did not finish", 32'(cyc), 32'(RUN_CYC));
                break;
            end
        end
    endtask

    logic [15:0] sig1;

    initial begin : watchdog
        #(64'd4000000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 scan_en in reset", 32'(scan_en), 32'd0);
        check("R1 done/pass/fail in reset", {29'd0, done, pass, fail}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 idle after reset", {28'd0, scan_en, done, pass, fail}, 32'd0);

        // run 1: chains preloaded with zeros, expected value 0
        @(posedge clk); #1; preload = 1'b1; preload_val = '0;
        @(posedge clk); #1; preload = 1'b0;
        push_stream();
        run(16'h0000, 1'b0);
        check("R4 cycles start to done (run 1)", 32'(cyc), 32'(RUN_CYC));
        check("R3 shift cycle count", 32'(hi), 32'((NP + 1) * LEN));
        check("R3 low cycle count", 32'(lo), 32'(NP + 1));
        check("R3 shift runs of CHAIN_LEN before each low", 32'(badrun), 32'd0);
        check("R5/R6 chain input stream", {bad_act, bad_exp}, {bad_exp, bad_exp});
        check("R5/R6 stream mismatches", 32'(stream_err), 32'd0);
        check("R6 all patterns consumed", 32'(exp_q.size()), 32'd0);
        sig1 = ref_sig;
        check("R8 verdict vs zero expectation",
              {30'd0, pass, fail}, (sig1 == 16'h0) ? 32'd2 : 32'd1);

        // R9: verdict holds without start
        repeat (12) @(posedge clk);
        @(negedge clk);
        check("R9 done/verdict held", {29'd0, done, pass, fail},
              (sig1 == 16'h0) ? 32'd6 : 32'd5);

        // run 2: different stale chain contents, correct expectation, starts poked mid-run
        @(posedge clk); #1; preload = 1'b1; preload_val = 8'hA5;
        @(posedge clk); #1; preload = 1'b0;
        stream_err = 0;
        push_stream();
        run(sig1, 1'b1);
        check("R2 cycles unchanged by mid-run start", 32'(cyc), 32'(RUN_CYC));
        check("R10 reference signature independent of stale contents", 32'(ref_sig), 32'(sig1));
        check("R7/R10 pass with matching signature", {29'd0, done, pass, fail}, 32'd6);
        check("R5/R6 reseeded stream", 32'(stream_err), 32'd0);

        // run 3: wrong expectation
        stream_err = 0;
        push_stream();
        run(sig1 ^ 16'h0001, 1'b0);
        check("R8 fail on mismatched signature", {29'd0, done, pass, fail}, 32'd5);
        check("R4 cycles start to done (run 3)", 32'(cyc), 32'(RUN_CYC));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule